// File: doc/BRIEF.md
# Serial Port Reset and Pin-State Controller

This block decides, for a synchronous serial port with separate receive and transmit sections and an internal sample rate generator, which parts of the port are held in reset and what every serial pin does while they are. It takes an active-low device reset and four software enable bits, one each for receiver, transmitter, generator and generator frame sync. A bit of 0 means "hold in reset". It also takes per-section direction and polarity bits, the raw generated clock and frame sync, and the frame-sync pins as inputs. From these it drives an output-enable and a value for each clock and frame-sync pin, the transmit data output-enable, the gated generator clock and frame sync, level strobes that clear each section's status flags, and one-cycle start qualifiers for the two sections.

Each section runs a small state machine with four states. ST_HOLD means the section is in reset. ST_SKIP counts frame-sync edges that are to be discarded. ST_ARMED waits for the qualifying edge. ST_LIVE means frames are running. The transitions are:
- `enable` takes ST_HOLD to ST_SKIP when the section discards edges, and to ST_ARMED otherwise.
- `skip_done` takes ST_SKIP to ST_ARMED on the last discarded edge.
- `start` takes ST_ARMED to ST_LIVE and emits the start pulse.
- `disable` takes any state back to ST_HOLD.

The transmitter discards one edge and the receiver discards none.

All software bits are registered in the port clock domain. Frame-sync pins pass through a two-stage synchronizer before edge detection.

Top module: `sport_rst_ctrl`

## Requirements
- R1: While `dev_rst_n` is low, every output-enable (`dx_oe`, clock and frame-sync pins) is 0, both flag-clear strobes are 1, both start outputs are 0, and `clkg_o`/`fsg_o` are 0.
- R2: Device reset clears all registered software bits, so after release both sections stay in reset until software sets their bits. Any software or mode bit takes effect one clock after the edge that samples it.
- R3: `dx_oe` is 0 whenever the sampled transmitter enable is 0.
- R4: Each clock and frame-sync pin output-enable equals its sampled direction bit (1 = output), whether or not its section is in reset.
- R5: A frame-sync pin of a section in reset drives its polarity bit, which is its idle level (polarity 1 = active low, idle high). This holds even while the generator frame sync is pulsing.
- R6: Clock pin values equal `gen_clk` when the generator enable is 1 and are 0 when it is 0.
- R7: `fsg_o` equals `gen_fs` only when both the generator and the frame-sync enables are 1, and is 0 otherwise. `clkg_o` is 0 when the generator enable is 0.
- R8: Each flag-clear strobe is 1 exactly while its section's sampled enable is 0.
- R9: While one section is in reset, the other section's frame-sync output still follows `fsg_o`, driving the active level (the inverse of its polarity) when `fsg_o` is 1.
- R10: `tx_start` is a one-cycle pulse on the second active frame-sync edge after the transmitter is enabled. The first edge and all later edges give no pulse, and disabling then enabling again re-arms the count.
- R11: `rx_start` is a one-cycle pulse on the first active frame-sync edge after the receiver is enabled.
- R12: An edge arriving on a frame-sync pin produces its start pulse after the third rising clock edge that follows the pin change. A generator frame-sync edge produces it after the first.
- R13: A section whose frame-sync direction bit is 1 counts edges of `fsg_o` and ignores its pin. With the bit at 0 it counts pin edges, where the active level is the pin value XOR the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| dev_rst_n | input | 1 | Asynchronous device reset, active low |
| sw_rx_en | input | 1 | Receiver enable (0 = hold in reset) |
| sw_tx_en | input | 1 | Transmitter enable (0 = hold in reset) |
| sw_gen_en | input | 1 | Sample rate generator enable |
| sw_fgen_en | input | 1 | Generator frame-sync enable |
| rx_clk_dir | input | 1 | Receive clock pin direction, 1 = output |
| rx_fs_dir | input | 1 | Receive frame-sync pin direction, 1 = output from generator |
| tx_clk_dir | input | 1 | Transmit clock pin direction, 1 = output |
| tx_fs_dir | input | 1 | Transmit frame-sync pin direction, 1 = output from generator |
| rx_fs_pol | input | 1 | Receive frame-sync polarity, 1 = active low |
| tx_fs_pol | input | 1 | Transmit frame-sync polarity, 1 = active low |
| gen_clk | input | 1 | Raw generator clock level |
| gen_fs | input | 1 | Raw generator frame-sync level |
| rx_fs_pin | input | 1 | Receive frame-sync pin input (asynchronous) |
| tx_fs_pin | input | 1 | Transmit frame-sync pin input (asynchronous) |
| dx_oe | output | 1 | Transmit data output-enable, 0 = high impedance |
| rx_clk_oe | output | 1 | Receive clock pin output-enable |
| rx_clk_o | output | 1 | Receive clock pin value |
| rx_fs_oe | output | 1 | Receive frame-sync pin output-enable |
| rx_fs_o | output | 1 | Receive frame-sync pin value |
| tx_clk_oe | output | 1 | Transmit clock pin output-enable |
| tx_clk_o | output | 1 | Transmit clock pin value |
| tx_fs_oe | output | 1 | Transmit frame-sync pin output-enable |
| tx_fs_o | output | 1 | Transmit frame-sync pin value |
| clkg_o | output | 1 | Gated generator clock |
| fsg_o | output | 1 | Gated generator frame sync |
| rx_flag_clr | output | 1 | Receive status flag clear strobe |
| tx_flag_clr | output | 1 | Transmit status flag clear strobe |
| rx_start | output | 1 | Receive start qualifier pulse |
| tx_start | output | 1 | Transmit start qualifier pulse |

## Verification
The hardest situation to reach is the transmitter state machine at exactly the second qualifying edge, with its source chosen by the direction bit. The bench has to make the ignored edge, the qualifying edge and a later extra edge distinguishable at the ports. It sends separate frame-sync pulses with idle gaps, once through the synchronized pin and once from the generator. It counts `tx_start` pulses after each pulse and samples the exact cycle of the qualifying pulse. It then disables and re-enables the transmitter to show that the count re-arms, and toggles the unselected source to show that it is ignored.

// File: rtl/sport_rst_pkg.sv
package sport_rst_pkg;

    // Per-section reset/start state machine states
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // section in reset
        ST_SKIP  = 2'd1,   // discarding leading frame-sync edges
        ST_ARMED = 2'd2,   // waiting for the qualifying edge
        ST_LIVE  = 2'd3    // frames running
    } sec_state_t;

    // Registered per-section configuration
    typedef struct packed {
        logic en;       // 1 = section out of reset
        logic clk_dir;  // 1 = clock pin is an output
        logic fs_dir;   // 1 = frame-sync pin is an output fed by the generator
        logic fs_pol;   // 1 = frame sync active low
    } sec_cfg_t;

    localparam int NUM_SEC = 2;
    localparam int SEC_RX  = 0;
    localparam int SEC_TX  = 1;

endpackage

// File: rtl/sport_fs_sync.sv
module sport_fs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[LAST];

endmodule

// File: rtl/sport_sec_fsm.sv
module sport_sec_fsm
    import sport_rst_pkg::*;
#(
    parameter int IGNORE_FS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fs_active,
    output logic go
);
    localparam int CNT_W   = (IGNORE_FS > 1) ? $clog2(IGNORE_FS) : 1;
    localparam int LAST_IG = (IGNORE_FS > 0) ? IGNORE_FS - 1 : 0;

    sec_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;
    logic             edge_s;
    logic             go_q;

    assign edge_s = fs_active && !prev_q;

    // state register, edge history and skip counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            prev_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= fs_active;
            if (state_d != ST_SKIP)              cnt_q <= '0;
            else if (state_q == ST_SKIP && edge_s) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = (IGNORE_FS > 0) ? ST_SKIP : ST_ARMED;
                ST_SKIP:  if (edge_s && cnt_q == CNT_W'(LAST_IG)) state_d = ST_ARMED;
                ST_ARMED: if (edge_s) state_d = ST_LIVE;
                ST_LIVE:  state_d = ST_LIVE;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= en && (state_q == ST_ARMED) && edge_s;
    end

    assign go = go_q;

    p_single_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q);

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_HOLD));

endmodule

// File: rtl/sport_pin_ctrl.sv
module sport_pin_ctrl
    import sport_rst_pkg::*;
(
    input  sec_cfg_t cfg,
    input  logic     clkg,
    input  logic     fsg,
    output logic     clk_oe,
    output logic     clk_o,
    output logic     fs_oe,
    output logic     fs_o,
    output logic     flag_clr
);
    always_comb begin
        clk_oe   = cfg.clk_dir;
        clk_o    = clkg;
        fs_oe    = cfg.fs_dir;
        fs_o     = cfg.en ? (fsg ^ cfg.fs_pol) : cfg.fs_pol;
        flag_clr = !cfg.en;
    end
endmodule

// File: rtl/sport_rst_ctrl.sv
module sport_rst_ctrl
    import sport_rst_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int RX_IGNORE_FS = 0,
    parameter int TX_IGNORE_FS = 1
) (
    input  logic clk,
    input  logic dev_rst_n,
    input  logic sw_rx_en,
    input  logic sw_tx_en,
    input  logic sw_gen_en,
    input  logic sw_fgen_en,
    input  logic rx_clk_dir,
    input  logic rx_fs_dir,
    input  logic tx_clk_dir,
    input  logic tx_fs_dir,
    input  logic rx_fs_pol,
    input  logic tx_fs_pol,
    input  logic gen_clk,
    input  logic gen_fs,
    input  logic rx_fs_pin,
    input  logic tx_fs_pin,
    output logic dx_oe,
    output logic rx_clk_oe,
    output logic rx_clk_o,
    output logic rx_fs_oe,
    output logic rx_fs_o,
    output logic tx_clk_oe,
    output logic tx_clk_o,
    output logic tx_fs_oe,
    output logic tx_fs_o,
    output logic clkg_o,
    output logic fsg_o,
    output logic rx_flag_clr,
    output logic tx_flag_clr,
    output logic rx_start,
    output logic tx_start
);
    localparam int IGN [NUM_SEC] = '{RX_IGNORE_FS, TX_IGNORE_FS};

    sec_cfg_t cfg_q  [NUM_SEC];
    sec_cfg_t cfg_d  [NUM_SEC];
    logic     pin_in [NUM_SEC];
    logic     gen_en_q, fgen_en_q;
    logic     clkg, fsg;

    logic clk_oe_s [NUM_SEC];
    logic clk_o_s  [NUM_SEC];
    logic fs_oe_s  [NUM_SEC];
    logic fs_o_s   [NUM_SEC];
    logic clr_s    [NUM_SEC];
    logic go_s     [NUM_SEC];

    always_comb begin
        cfg_d[SEC_RX] = '{en: sw_rx_en, clk_dir: rx_clk_dir, fs_dir: rx_fs_dir, fs_pol: rx_fs_pol};
        cfg_d[SEC_TX] = '{en: sw_tx_en, clk_dir: tx_clk_dir, fs_dir: tx_fs_dir, fs_pol: tx_fs_pol};
        pin_in[SEC_RX] = rx_fs_pin;
        pin_in[SEC_TX] = tx_fs_pin;
    end

    // generator gating
    always_ff @(posedge clk or negedge dev_rst_n) begin
        if (!dev_rst_n) begin
            gen_en_q  <= 1'b0;
            fgen_en_q <= 1'b0;
        end else begin
            gen_en_q  <= sw_gen_en;
            fgen_en_q <= sw_fgen_en;
        end
    end

    assign clkg = gen_clk & gen_en_q;
    assign fsg  = gen_fs & gen_en_q & fgen_en_q;

    for (genvar i = 0; i < NUM_SEC; i++) begin : g_sec
        logic pin_sync;
        logic fs_active;

        always_ff @(posedge clk or negedge dev_rst_n) begin
            if (!dev_rst_n) cfg_q[i] <= '0;
            else            cfg_q[i] <= cfg_d[i];
        end

        sport_fs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (dev_rst_n),
            .d     (pin_in[i]),
            .q     (pin_sync)
        );

        assign fs_active = cfg_q[i].fs_dir ? fsg : (pin_sync ^ cfg_q[i].fs_pol);

        sport_sec_fsm #(.IGNORE_FS(IGN[i])) u_fsm (
            .clk       (clk),
            .rst_n     (dev_rst_n),
            .en        (cfg_q[i].en),
            .fs_active (fs_active),
            .go        (go_s[i])
        );

        sport_pin_ctrl u_pins (
            .cfg      (cfg_q[i]),
            .clkg     (clkg),
            .fsg      (fsg),
            .clk_oe   (clk_oe_s[i]),
            .clk_o    (clk_o_s[i]),
            .fs_oe    (fs_oe_s[i]),
            .fs_o     (fs_o_s[i]),
            .flag_clr (clr_s[i])
        );
    end

    assign dx_oe       = cfg_q[SEC_TX].en;
    assign rx_clk_oe   = clk_oe_s[SEC_RX];
    assign rx_clk_o    = clk_o_s[SEC_RX];
    assign rx_fs_oe    = fs_oe_s[SEC_RX];
    assign rx_fs_o     = fs_o_s[SEC_RX];
    assign tx_clk_oe   = clk_oe_s[SEC_TX];
    assign tx_clk_o    = clk_o_s[SEC_TX];
    assign tx_fs_oe    = fs_oe_s[SEC_TX];
    assign tx_fs_o     = fs_o_s[SEC_TX];
    assign clkg_o      = clkg;
    assign fsg_o       = fsg;
    assign rx_flag_clr = clr_s[SEC_RX];
    assign tx_flag_clr = clr_s[SEC_TX];
    assign rx_start    = go_s[SEC_RX];
    assign tx_start    = go_s[SEC_TX];

    // checks
    always_comb begin
        if (dev_rst_n === 1'b0) begin
            p_dev_rst_r1: assert (!dx_oe && !rx_clk_oe && !rx_fs_oe && !tx_clk_oe && !tx_fs_oe
                                  && rx_flag_clr && tx_flag_clr && !rx_start && !tx_start);
        end
    end

    p_dx_hiz_r3: assert property (@(posedge clk) disable iff (!dev_rst_n)
        ($past(dev_rst_n) && !$past(sw_tx_en)) |-> !dx_oe);

    p_dir_r4: assert property (@(posedge clk) disable iff (!dev_rst_n)
        $past(dev_rst_n) |-> (rx_clk_oe == $past(rx_clk_dir) && tx_fs_oe == $past(tx_fs_dir)));

    p_fs_idle_r5: assert property (@(posedge clk) disable iff (!dev_rst_n)
        ($past(dev_rst_n) && !$past(sw_rx_en) && rx_fs_oe) |-> (rx_fs_o == $past(rx_fs_pol)));

    p_gen_low_r7: assert property (@(posedge clk) disable iff (!dev_rst_n)
        ($past(dev_rst_n) && !$past(sw_gen_en)) |-> (!clkg_o && !fsg_o && !tx_clk_o && !rx_clk_o));

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!dev_rst_n)
        ($past(dev_rst_n) && !$past(sw_tx_en)) |-> tx_flag_clr);

endmodule

// File: tb/sport_rst_ctrl_tb.sv
module sport_rst_ctrl_tb_top;

    logic clk = 1'b0;
    logic dev_rst_n;
    logic sw_rx_en, sw_tx_en, sw_gen_en, sw_fgen_en;
    logic rx_clk_dir, rx_fs_dir, tx_clk_dir, tx_fs_dir, rx_fs_pol, tx_fs_pol;
    logic gen_clk, gen_fs, rx_fs_pin, tx_fs_pin;
    logic dx_oe, rx_clk_oe, rx_clk_o, rx_fs_oe, rx_fs_o;
    logic tx_clk_oe, tx_clk_o, tx_fs_oe, tx_fs_o, clkg_o, fsg_o;
    logic rx_flag_clr, tx_flag_clr, rx_start, tx_start;

    int n_chk  = 0;
    int n_fail = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sport_rst_ctrl dut_i (.*);

    always @(negedge clk) begin
        if (tx_start === 1'b1) tx_cnt++;
        if (rx_start === 1'b1) rx_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stimulus: rx tx gen fgen | rclkdir rfsdir tclkdir tfsdir | rpol tpol gclk gfs
    // expected: dx rcoe rco rfoe rfo tcoe tco tfoe tfo clkg fsg rxclr txclr
    localparam int NV = 7;
    localparam logic [24:0] VEC [NV] = '{
        {12'b0000_0000_0000, 13'b0000000000011},
        {12'b0011_1111_1011, 13'b0111111101111},
        {12'b1011_1111_0111, 13'b0111111111101},
        {12'b1101_1111_0011, 13'b1101010100000},
        {12'b1110_1111_1111, 13'b1111111111000},
        {12'b0111_0011_1101, 13'b1000110100110},
        {12'b1111_1111_0000, 13'b1101010100000}
    };

    task automatic apply(input logic [11:0] s);
        {sw_rx_en, sw_tx_en, sw_gen_en, sw_fgen_en,
         rx_clk_dir, rx_fs_dir, tx_clk_dir, tx_fs_dir,
         rx_fs_pol, tx_fs_pol, gen_clk, gen_fs} = s;
    endtask

    function automatic logic [12:0] pins();
        return {dx_oe, rx_clk_oe, rx_clk_o, rx_fs_oe, rx_fs_o, tx_clk_oe, tx_clk_o,
                tx_fs_oe, tx_fs_o, clkg_o, fsg_o, rx_flag_clr, tx_flag_clr};
    endfunction

    // active-low pin pulse on tx (pol=1): low for 2 cycles then idle 5
    task automatic tx_pin_pulse();
        tx_fs_pin = 1'b0; cyc(2);
        tx_fs_pin = 1'b1; cyc(5);
    endtask

    task automatic gen_pulse();
        gen_fs = 1'b1; cyc(1);
        gen_fs = 1'b0; cyc(4);
    endtask

    initial begin : main
        int base;
        dev_rst_n = 1'b0;
        apply(12'b1111_1111_1111);
        rx_fs_pin = 1'b0; tx_fs_pin = 1'b1;
        cyc(3);
        chk(pins() == 13'b0000000000011, "R1 outputs in device reset", pins(), 13'b0000000000011);
        chk(!rx_start && !tx_start, "R1 starts low in device reset", {rx_start, tx_start}, 0);

        apply(12'b0000_0000_0000);
        dev_rst_n = 1'b1;
        cyc(4);
        chk(rx_flag_clr && tx_flag_clr && !dx_oe, "R2 sections stay in reset after release",
            {rx_flag_clr, tx_flag_clr, dx_oe}, 3'b110);
        sw_rx_en = 1'b1;
        #1;
        chk(rx_flag_clr == 1'b1, "R2 bit not yet sampled", rx_flag_clr, 1);
        cyc(1);
        chk(rx_flag_clr == 1'b0, "R2 bit effective after one clock", rx_flag_clr, 0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][24:13]);
            cyc(2);
            chk(pins() == VEC[v][12:0], $sformatf("R4/R5/R6/R7/R8/R3 vector %0d", v), pins(), VEC[v][12:0]);
        end

        // transmitter, pin source, active low
        apply(12'b0000_0000_0100);
        tx_fs_pin = 1'b1;
        cyc(3);
        sw_tx_en = 1'b1;
        cyc(5);
        base = tx_cnt;
        tx_pin_pulse();
        chk(tx_cnt == base, "R10 first frame sync ignored", tx_cnt - base, 0);
        tx_fs_pin = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(tx_start == 1'b0, "R12 no start before third edge", tx_start, 0);
        @(negedge clk);
        chk(tx_start == 1'b1, "R12 R10 start after third edge on second sync", tx_start, 1);
        @(negedge clk);
        chk(tx_start == 1'b0, "R10 start lasts one cycle", tx_start, 0);
        tx_fs_pin = 1'b1; cyc(5);
        tx_pin_pulse();
        chk(tx_cnt == base + 1, "R10 later syncs give no start", tx_cnt - base, 1);

        sw_tx_en = 1'b0; cyc(3);
        sw_tx_en = 1'b1; cyc(3);
        base = tx_cnt;
        tx_pin_pulse();
        chk(tx_cnt == base, "R10 re-armed first sync ignored", tx_cnt - base, 0);
        tx_pin_pulse();
        chk(tx_cnt == base + 1, "R10 re-armed second sync starts", tx_cnt - base, 1);

        // generator source: tx running, rx in reset with fs pin output
        sw_tx_en = 1'b0;
        sw_rx_en = 1'b0; rx_fs_dir = 1'b1; rx_fs_pol = 1'b0;
        tx_fs_dir = 1'b1; tx_fs_pol = 1'b0;
        sw_gen_en = 1'b1; sw_fgen_en = 1'b1;
        cyc(3);
        sw_tx_en = 1'b1; cyc(3);
        base = tx_cnt;
        tx_pin_pulse();
        tx_pin_pulse();
        chk(tx_cnt == base, "R13 pin ignored when sync comes from generator", tx_cnt - base, 0);
        gen_fs = 1'b1;
        #1;
        chk(tx_fs_o == 1'b1 && fsg_o == 1'b1, "R9 running section follows generator sync",
            {tx_fs_o, fsg_o}, 2'b11);
        chk(rx_fs_o == 1'b0, "R5 reset section frame sync idle while generator pulses", rx_fs_o, 0);
        cyc(1); gen_fs = 1'b0; cyc(4);
        chk(tx_cnt == base, "R10 first generator sync ignored", tx_cnt - base, 0);
        gen_fs = 1'b1;
        @(negedge clk);
        chk(tx_start == 1'b1, "R12 generator sync start after one edge", tx_start, 1);
        gen_fs = 1'b0; cyc(4);
        gen_pulse();
        chk(tx_cnt == base + 1, "R10 only one start per enable", tx_cnt - base, 1);

        // receiver, pin source, active high
        rx_fs_dir = 1'b0; rx_fs_pol = 1'b0; rx_fs_pin = 1'b0;
        cyc(3);
        sw_rx_en = 1'b1; cyc(4);
        base = rx_cnt;
        rx_fs_pin = 1'b1; cyc(2); rx_fs_pin = 1'b0; cyc(5);
        chk(rx_cnt == base + 1, "R11 receiver starts on first sync", rx_cnt - base, 1);

        sw_gen_en = 1'b0; gen_clk = 1'b1; gen_fs = 1'b1; cyc(2);
        chk(!clkg_o && !fsg_o && !tx_clk_o, "R6 R7 generator off forces low",
            {clkg_o, fsg_o, tx_clk_o}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(5 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule